// File: doc/BRIEF.md
# Bridge control register file

A 32-bit control and status register bank for the host side of a CPU-to-PCI bridge. It holds 28 word slots at byte offsets 0x00 through 0x6C: configuration words, PCI window maps, GPIO, interrupt routing words, an interrupt enable with separate set and clear aliases, an interrupt status word, four mailboxes, and cache and timing words. The word index of an access is its byte offset shifted right by two.

The register bus is a single-request port. A request with `we_i` high is a write and one with `we_i` low is a read. Every read returns its data on `rdata_o` with `rvalid_o` exactly one cycle later. Only whole-word accesses act: all four byte enables must be set and the two low address bits must be zero.

A write that moves bit 2 of the general configuration word (offset 0x04) from 0 to 1 raises a one-cycle software reset request. The register bank itself is left alone by that request.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: After reset, offsets hold 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000, and every other slot holds zero. After reset, `rvalid_o` and `sw_rst_req_o` are low.
- R2: A read request returns data with `rvalid_o` high for exactly the next cycle. Write requests and idle cycles never raise `rvalid_o`. Back-to-back reads return data in issue order.
- R3: Every slot other than 0x04, 0x30, 0x34, 0x38 and 0x3C is plain storage, including the mailboxes at 0x40–0x4C. A whole-word write is read back unchanged.
- R4: A write to 0x30 stores the written value, which reads back at 0x30, and ORs it into the enable word at 0x38.
- R5: A write to 0x34 stores the written value, which reads back at 0x34, and clears the written 1 bits in the enable word at 0x38.
- R6: Writes to 0x38 and 0x3C are ignored. 0x3C always reads zero.
- R7: A whole-word write to 0x04 is stored. If it carries bit 2 = 1 while the stored bit 2 is 0, `sw_rst_req_o` is high for exactly the one cycle after the write.
- R8: A write to 0x04 that leaves bit 2 at 0, or writes 1 where 1 is already stored, raises no request. A request clears no register.
- R9: An access with `be_i` other than 4'hF, or with `addr_i[1:0]` nonzero, is not whole-word. Such a write changes nothing and raises no request. Such a read returns zero, still with `rvalid_o`.
- R10: Offsets above 0x6C are unmapped. Writes to them have no effect, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; only 4'hF acts |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| rdata_o | output | 32 | Read data |
| sw_rst_req_o | output | 1 | One-cycle software reset request |

## Verification
The assertions assume that `req_i` and its qualifiers are stable across the sampling edge and never X while out of reset. They also assume that a reset request can only come from a write issued in the immediately preceding cycle. The bench drives every input on the falling edge and holds it through the following rising edge. It issues at most one access per cycle and never leaves a request undefined. It deliberately mixes partial, misaligned and out-of-range accesses with whole-word ones, so that the zero-read and ignored-write paths are hit under these same assumptions.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned BE_W         = DATA_W / 8;
  localparam int unsigned NUM_WORDS    = 28;
  localparam int unsigned IDX_GENCFG   = 1;
  localparam int unsigned IDX_IEN_SET  = 12;
  localparam int unsigned IDX_IEN_CLR  = 13;
  localparam int unsigned IDX_IEN      = 14;
  localparam int unsigned IDX_ISTAT    = 15;
  localparam int unsigned RST_TRIG_BIT = 2;

  typedef enum logic [1:0] {
    SLOT_PLAIN,
    SLOT_ENABLE,
    SLOT_RDONLY
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(int unsigned idx);
    if (idx == IDX_IEN)   return SLOT_ENABLE;
    if (idx == IDX_ISTAT) return SLOT_RDONLY;
    return SLOT_PLAIN;
  endfunction

  function automatic logic [DATA_W-1:0] slot_reset(int unsigned idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/hbr_access_decode.sv
module hbr_access_decode
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned WIDX_W = ADDR_W - 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WIDX_W-1:0] word_idx_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              rd_ok_o
);

  logic whole_word;
  logic in_range;

  assign word_idx_o = addr_i[ADDR_W-1:2];
  assign whole_word = (be_i == {BE_W{1'b1}}) && (addr_i[1:0] == 2'b00);
  assign in_range   = ({{(32-WIDX_W){1'b0}}, word_idx_o} < NUM_WORDS);

  assign wr_o    = req_i && we_i && whole_word;
  assign rd_o    = req_i && !we_i;
  assign rd_ok_o = whole_word && in_range;

endmodule

// File: rtl/hbr_slot_bank.sv
module hbr_slot_bank
  import hbr_pkg::*;
#(
  parameter int unsigned WIDX_W = 6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [WIDX_W-1:0]                   wr_idx_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    slot_q_o
);

  logic set_hit;
  logic clr_hit;

  assign set_hit = wr_i && (wr_idx_i == WIDX_W'(IDX_IEN_SET));
  assign clr_hit = wr_i && (wr_idx_i == WIDX_W'(IDX_IEN_CLR));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
    if (slot_kind(i) == SLOT_RDONLY) begin : g_ro
      assign slot_q_o[i] = slot_reset(i);
    end else if (slot_kind(i) == SLOT_ENABLE) begin : g_en
      logic [DATA_W-1:0] en_q;
      // only reachable through the set/clear aliases
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      en_q <= slot_reset(i);
        else if (set_hit) en_q <= en_q | wdata_i;
        else if (clr_hit) en_q <= en_q & ~wdata_i;
      end
      assign slot_q_o[i] = en_q;
    end else begin : g_rw
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          word_q <= slot_reset(i);
        else if (wr_i && (wr_idx_i == WIDX_W'(i)))
          word_q <= wdata_i;
      end
      assign slot_q_o[i] = word_q;
    end
  end

endmodule

// File: rtl/hbr_reset_trigger.sv
module hbr_reset_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic req_o
);

  logic req_q;

  // rising edge of the stored bit, seen at write time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= cfg_wr_i && !old_bit_i && new_bit_i;
  end

  assign req_o = req_q;

endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sw_rst_req_o
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]                word_idx;
  logic                             wr;
  logic                             rd;
  logic                             rd_ok;
  logic [NUM_WORDS-1:0][DATA_W-1:0] slot_q;
  logic [DATA_W-1:0]                rd_mux;
  logic                             cfg_wr;
  logic                             rvalid_q;
  logic [DATA_W-1:0]                rdata_q;

  hbr_access_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i      (req_i),
    .we_i       (we_i),
    .be_i       (be_i),
    .addr_i     (addr_i),
    .word_idx_o (word_idx),
    .wr_o       (wr),
    .rd_o       (rd),
    .rd_ok_o    (rd_ok)
  );

  hbr_slot_bank #(.WIDX_W(WIDX_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wr_idx_i (word_idx),
    .wdata_i  (wdata_i),
    .slot_q_o (slot_q)
  );

  assign cfg_wr = wr && (word_idx == WIDX_W'(IDX_GENCFG));

  hbr_reset_trigger u_rst_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (cfg_wr),
    .old_bit_i (slot_q[IDX_GENCFG][RST_TRIG_BIT]),
    .new_bit_i (wdata_i[RST_TRIG_BIT]),
    .req_o     (sw_rst_req_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int unsigned i = 0; i < NUM_WORDS; i++) begin
      if (word_idx == WIDX_W'(i)) rd_mux = slot_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/hbr_ctrl_regs_chk.sv
module hbr_ctrl_regs_chk
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [BE_W-1:0]   be_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sw_rst_req_o
);

  logic partial;
  logic unmapped;

  assign partial  = (be_i != {BE_W{1'b1}}) || (addr_i[1:0] != 2'b00);
  assign unmapped = ({{(34-ADDR_W){1'b0}}, addr_i[ADDR_W-1:2]} >= NUM_WORDS);

  // R2
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R2
  no_stray_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R7
  rst_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_o |=> !sw_rst_req_o);

  // R7
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_rst_req_o) |-> $past(req_i && we_i && !partial &&
                                  addr_i[ADDR_W-1:2] == (ADDR_W-2)'(IDX_GENCFG) &&
                                  wdata_i[RST_TRIG_BIT]));

  // R9
  partial_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && partial) |=> (rdata_o == '0));

  // R10
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |=> (rdata_o == '0));

endmodule

bind hbr_ctrl_regs hbr_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .be_i         (be_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rvalid_o     (rvalid_o),
  .rdata_o      (rdata_o),
  .sw_rst_req_o (sw_rst_req_o)
);

// File: tb/hbr_ctrl_regs_tb_top.sv
module hbr_ctrl_regs_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = 4'h0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o;
  logic [31:0] rdata_o;
  logic        sw_rst_req_o;

  int n_checks = 0;
  int n_errors = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  hbr_ctrl_regs #(.ADDR_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .be_i(be_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .sw_rst_req_o(sw_rst_req_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reset_val(int idx);
    case (idx)
      0: return 32'h0000_0C40;   1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;   3: return 32'h255E_0091;
      4: return 32'h0000_6140;   7: return 32'h0000_01FF;
      8: return 32'h0000_01FF;  26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(int idx);
    return 32'h5A5A_0000 ^ (idx * 32'h0001_0203);
  endfunction

  // driver: one access per cycle, launched on the falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag,
                    input logic [3:0] be = 4'hF);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; be_i = be;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  always @(posedge clk_i) rd_seen <= rst_ni && req_i && !we_i;

  // monitor: compares each returned word against the scoreboard head
  always @(negedge clk_i) begin
    if (rst_ni && (rvalid_o || rd_seen)) begin
      check(rvalid_o == rd_seen, "R2 rvalid timing", {31'b0, rvalid_o}, {31'b0, rd_seen});
      if (rvalid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected read data", rdata_o, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rdata_o == e, t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(rvalid_o == 1'b0, "R1 rvalid in reset", {31'b0, rvalid_o}, 32'h0);
    check(sw_rst_req_o == 1'b0, "R1 reset request in reset", {31'b0, sw_rst_req_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset contents, issued back to back (also R2 ordering)
    for (int i = 0; i < 28; i++) rd(8'(i * 4), reset_val(i), "R1 reset value");

    // R3: plain storage incl. mailboxes
    for (int i = 0; i < 28; i++)
      if (!(i == 1 || (i >= 12 && i <= 15))) wr(8'(i * 4), pat(i));
    for (int i = 0; i < 28; i++)
      if (!(i == 1 || (i >= 12 && i <= 15))) rd(8'(i * 4), pat(i), "R3 plain readback");
    idle(1);

    // R4: set alias
    wr(8'h30, 32'h0000_00F0);
    rd(8'h38, 32'h0000_00F0, "R4 enable after set");
    rd(8'h30, 32'h0000_00F0, "R4 set alias readback");
    wr(8'h30, 32'h0000_0F00);
    rd(8'h38, 32'h0000_0FF0, "R4 enable accumulates");

    // R5: clear alias
    wr(8'h34, 32'h0000_0030);
    rd(8'h38, 32'h0000_0FC0, "R5 enable after clear");
    rd(8'h34, 32'h0000_0030, "R5 clear alias readback");

    // R6: read-only words
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h0000_0FC0, "R6 enable write ignored");
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, 32'h0, "R6 status reads zero");

    // R7/R8: reset request
    wr(8'h04, 32'h0000_1380);
    check(sw_rst_req_o == 1'b0, "R8 no request on bit cleared", {31'b0, sw_rst_req_o}, 32'h0);
    wr(8'h04, 32'h0000_1384);
    check(sw_rst_req_o == 1'b1, "R7 request after 0->1", {31'b0, sw_rst_req_o}, 32'h1);
    @(negedge clk_i);
    check(sw_rst_req_o == 1'b0, "R7 request one cycle", {31'b0, sw_rst_req_o}, 32'h0);
    rd(8'h04, 32'h0000_1384, "R7 value stored");
    wr(8'h04, 32'h0000_1384);
    check(sw_rst_req_o == 1'b0, "R8 no request on 1->1", {31'b0, sw_rst_req_o}, 32'h0);
    rd(8'h00, pat(0), "R8 request clears nothing");
    rd(8'h38, 32'h0000_0FC0, "R8 enable kept");

    // R9: partial and misaligned accesses
    wr(8'h04, 32'h0000_1380);
    wr(8'h04, 32'h0000_1384, 4'h1);
    check(sw_rst_req_o == 1'b0, "R9 partial write no request", {31'b0, sw_rst_req_o}, 32'h0);
    rd(8'h04, 32'h0000_1380, "R9 partial write ignored");
    wr(8'h40, 32'hFFFF_FFFF, 4'h3);
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h40, pat(16), "R9 mailbox unchanged");
    rd(8'h40, 32'h0, "R9 partial read zero", 4'h1);
    rd(8'h41, 32'h0, "R9 misaligned read zero");

    // R10: unmapped offsets
    wr(8'h70, 32'hDEAD_BEEF);
    wr(8'hFC, 32'hDEAD_BEEF);
    rd(8'h70, 32'h0, "R10 unmapped read zero");
    rd(8'hFC, 32'h0, "R10 top read zero");
    rd(8'h00, pat(0), "R10 no aliasing");
    rd(8'h6C, pat(27), "R10 last slot intact");

    idle(3);
    check(exp_q.size() == 0, "R2 reads outstanding", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule